// File: doc/BRIEF.md
# Monitor Status Descriptor Ring Producer

This block follows a DMA engine as it writes TLV records into a monitor status buffer. It remembers the last dword touched in the current capture segment. When the segment ends, it posts a four-dword completion descriptor into a circular destination ring. A segment ends through truncation, flush, end of PPDU or a full status buffer. The descriptor holds the 64-bit status buffer address, a PPDU identifier and a control word. The control word packs the end offset, the end cause, the initiator flag, an always-zero empty flag, a fixed ring identity and a 4-bit wrap count. A consumer can use the wrap count to tell fresh entries from stale ones without reading a head pointer.

The producer keeps its own slot index into the ring and a wrap counter. The four dwords of a descriptor go out on consecutive cycles through a dword-indexed write port, and a one-cycle done pulse follows the last one. While the consumer side signals that the ring is full, the captured descriptor is held and nothing is written.

The state machine has six states. ST_IDLE waits for an end cause. ST_HOLD holds a captured descriptor while the ring is full. ST_W0, ST_W1, ST_W2 and ST_W3 write dwords 0 to 3. The transitions are:
- ST_IDLE goes to ST_W0 on an end cause while the ring is not full.
- ST_IDLE goes to ST_HOLD on an end cause while the ring is full.
- ST_HOLD stays in ST_HOLD while the ring is full, and goes to ST_W0 once it is not.
- ST_W0 goes to ST_W1, ST_W1 to ST_W2 and ST_W2 to ST_W3 unconditionally.
- ST_W3 goes to ST_IDLE and advances the slot.

Top module: `mon_desc_ring_producer`

## Requirements
- R1: A descriptor occupies ring dword indices slot*4+0 to slot*4+3 and is written on four consecutive cycles. Dword 0 is address bits 31:0, dword 1 is address bits 63:32, dword 2 is the PPDU identifier and dword 3 is the control word. The first write happens in the cycle after the end cause is sampled, when the ring is not full.
- R2: In the control word, bits 11:0 hold the end offset and bits 15:12 are zero. Bits 17:16 hold the end cause and bit 18 holds the initiator flag. Bit 19, the empty flag, is zero. Bits 27:20 hold the RING_ID parameter and bits 31:28 hold the wrap count.
- R3: The end offset, in dwords, is offset+size-1 of the last TLV write with a nonzero size. A TLV write in the same cycle as the end cause counts. A TLV write of size 0 is ignored. A segment start clears the tracked offset to 0, and a TLV write in the same cycle as the segment start applies after the clear.
- R4: The end cause is encoded as 0 for buffer full, 1 for flush, 2 for end of PPDU and 3 for truncation. When several causes fall in one cycle, the priority is truncation, then flush, then end of PPDU, then buffer full.
- R5: Dword 2 takes the schedule identifier when the initiator flag is 1, and the PHY PPDU identifier when it is 0. The flag is sampled together with the end cause.
- R6: The slot advances by one after each descriptor. When it rolls from the last slot to slot 0, the 4-bit wrap count increments, rolling over from 15 to 0. The wrap count is 0 from reset.
- R7: While ring_full is high before dword 0, no write occurs and the captured descriptor is kept unchanged. The descriptor is written once ring_full falls.
- R8: desc_done pulses for exactly one cycle, in the cycle after dword 3 is written.
- R9: desc_busy is high from the cycle after an end cause is accepted until desc_done. End causes that arrive while desc_busy is high are ignored.
- R10: After reset, ring_wr_en, desc_busy and desc_done are low, and the first descriptor goes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_start | input | 1 | Start of a new capture segment; clears the offset tracker |
| tlv_valid | input | 1 | A TLV write occurs this cycle |
| tlv_offset | input | 12 | Start offset of the TLV write, in dwords |
| tlv_size | input | 12 | Size of the TLV write, in dwords |
| ev_trunc | input | 1 | Truncation caused by a system error |
| ev_flush | input | 1 | Flush detected |
| ev_ppdu_end | input | 1 | End of PPDU |
| ev_buf_full | input | 1 | Status buffer full |
| initiator | input | 1 | 1 when the segment belongs to the initiator side |
| sched_id | input | 32 | Schedule identifier candidate |
| phy_ppdu_id | input | 32 | PHY PPDU identifier candidate |
| buf_addr | input | 64 | Status buffer address |
| ring_full | input | 1 | Consumer side has no free slot |
| ring_wr_en | output | 1 | Ring write strobe |
| ring_wr_idx | output | IDX_W | Ring dword index (slot*4 + dword) |
| ring_wr_data | output | 32 | Ring write data |
| desc_busy | output | 1 | A descriptor is being held or written |
| desc_done | output | 1 | One-cycle pulse after the last dword |

## Verification
Two things can fall in the same cycle: a TLV write and the end cause that closes its segment. The bench provokes this by raising a flush together with a TLV write, and by raising all four causes together. It judges the end offset and the cause code both against a behavioural model and against hand-computed control words. A further overlap comes from an end cause that arrives while the previous descriptor is still being written. The bench checks that only one descriptor reaches the ring.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

    localparam int OFF_W  = 12;
    localparam int WRAP_W = 4;

    typedef enum logic [1:0] {
        CAUSE_BUF_FULL = 2'd0,
        CAUSE_FLUSH    = 2'd1,
        CAUSE_PPDU_END = 2'd2,
        CAUSE_TRUNC    = 2'd3
    } end_cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_W0,
        ST_W1,
        ST_W2,
        ST_W3
    } prod_state_e;

    typedef struct packed {
        logic [63:0]      addr;
        logic [31:0]      ppdu;
        logic [OFF_W-1:0] end_off;
        end_cause_e       cause;
        logic             initiator;
    } desc_snap_t;

endpackage

// File: rtl/mdr_offset_tracker.sv
module mdr_offset_tracker
    import mdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_start,
    input  logic             tlv_valid,
    input  logic [OFF_W-1:0] tlv_offset,
    input  logic [OFF_W-1:0] tlv_size,
    output logic [OFF_W-1:0] end_off_next
);

    logic [OFF_W-1:0] end_off_q;

    always_comb begin
        end_off_next = seg_start ? '0 : end_off_q;
        if (tlv_valid && (tlv_size != '0)) begin
            end_off_next = tlv_offset + tlv_size - OFF_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_off_q <= '0;
        end else begin
            end_off_q <= end_off_next;
        end
    end

endmodule

// File: rtl/mdr_cause_arbiter.sv
module mdr_cause_arbiter
    import mdr_pkg::*;
(
    input  logic       ev_trunc,
    input  logic       ev_flush,
    input  logic       ev_ppdu_end,
    input  logic       ev_buf_full,
    output logic       any_cause,
    output end_cause_e cause
);

    assign any_cause = ev_trunc | ev_flush | ev_ppdu_end | ev_buf_full;

    always_comb begin
        if (ev_trunc) begin
            cause = CAUSE_TRUNC;
        end else if (ev_flush) begin
            cause = CAUSE_FLUSH;
        end else if (ev_ppdu_end) begin
            cause = CAUSE_PPDU_END;
        end else begin
            cause = CAUSE_BUF_FULL;
        end
    end

endmodule

// File: rtl/mdr_slot_counter.sv
module mdr_slot_counter
    import mdr_pkg::*;
#(
    parameter int DEPTH  = 4,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [SLOT_W-1:0] slot,
    output logic [WRAP_W-1:0] wrap_cnt
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot     <= '0;
            wrap_cnt <= '0;
        end else if (advance) begin
            if (slot == LAST_SLOT) begin
                slot     <= '0;
                wrap_cnt <= wrap_cnt + WRAP_W'(1);
            end else begin
                slot <= slot + SLOT_W'(1);
            end
        end
    end

endmodule

// File: rtl/mon_desc_ring_producer.sv
module mon_desc_ring_producer
    import mdr_pkg::*;
#(
    parameter int          DEPTH   = 4,
    parameter logic [7:0]  RING_ID = 8'hA7,
    localparam int         SLOT_W  = $clog2(DEPTH),
    localparam int         IDX_W   = SLOT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_start,
    input  logic             tlv_valid,
    input  logic [11:0]      tlv_offset,
    input  logic [11:0]      tlv_size,
    input  logic             ev_trunc,
    input  logic             ev_flush,
    input  logic             ev_ppdu_end,
    input  logic             ev_buf_full,
    input  logic             initiator,
    input  logic [31:0]      sched_id,
    input  logic [31:0]      phy_ppdu_id,
    input  logic [63:0]      buf_addr,
    input  logic             ring_full,
    output logic             ring_wr_en,
    output logic [IDX_W-1:0] ring_wr_idx,
    output logic [31:0]      ring_wr_data,
    output logic             desc_busy,
    output logic             desc_done
);

    prod_state_e       state_q, state_d;
    desc_snap_t        snap_q;
    logic [OFF_W-1:0]  end_off_next;
    logic              any_cause;
    end_cause_e        cause;
    logic [SLOT_W-1:0] slot;
    logic [WRAP_W-1:0] wrap_cnt;
    logic              advance;
    logic              accept;
    logic [1:0]        dword_sel;
    logic [31:0]       ctrl_word;

    mdr_offset_tracker u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .seg_start    (seg_start),
        .tlv_valid    (tlv_valid),
        .tlv_offset   (tlv_offset),
        .tlv_size     (tlv_size),
        .end_off_next (end_off_next)
    );

    mdr_cause_arbiter u_arb (
        .ev_trunc    (ev_trunc),
        .ev_flush    (ev_flush),
        .ev_ppdu_end (ev_ppdu_end),
        .ev_buf_full (ev_buf_full),
        .any_cause   (any_cause),
        .cause       (cause)
    );

    mdr_slot_counter #(.DEPTH(DEPTH)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .slot     (slot),
        .wrap_cnt (wrap_cnt)
    );

    assign accept  = (state_q == ST_IDLE) && any_cause;
    assign advance = (state_q == ST_W3);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_cause) state_d = ring_full ? ST_HOLD : ST_W0;
            ST_HOLD: if (!ring_full) state_d = ST_W0;
            ST_W0:   state_d = ST_W1;
            ST_W1:   state_d = ST_W2;
            ST_W2:   state_d = ST_W3;
            ST_W3:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, descriptor capture, completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            snap_q    <= '0;
            desc_done <= 1'b0;
        end else begin
            state_q   <= state_d;
            desc_done <= (state_q == ST_W3);
            if (accept) begin
                snap_q.addr      <= buf_addr;
                snap_q.ppdu      <= initiator ? sched_id : phy_ppdu_id;
                snap_q.end_off   <= end_off_next;
                snap_q.cause     <= cause;
                snap_q.initiator <= initiator;
            end
        end
    end

    assign ctrl_word = {wrap_cnt, RING_ID, 1'b0, snap_q.initiator,
                        snap_q.cause, 4'b0000, snap_q.end_off};

    // outputs decoded from state
    always_comb begin
        ring_wr_en = 1'b0;
        dword_sel  = 2'd0;
        desc_busy  = 1'b1;
        unique case (state_q)
            ST_IDLE: desc_busy = 1'b0;
            ST_HOLD: ;
            ST_W0: begin ring_wr_en = 1'b1; dword_sel = 2'd0; end
            ST_W1: begin ring_wr_en = 1'b1; dword_sel = 2'd1; end
            ST_W2: begin ring_wr_en = 1'b1; dword_sel = 2'd2; end
            ST_W3: begin ring_wr_en = 1'b1; dword_sel = 2'd3; end
            default: desc_busy = 1'b0;
        endcase
    end

    always_comb begin
        unique case (dword_sel)
            2'd0: ring_wr_data = snap_q.addr[31:0];
            2'd1: ring_wr_data = snap_q.addr[63:32];
            2'd2: ring_wr_data = snap_q.ppdu;
            default: ring_wr_data = ctrl_word;
        endcase
    end

    assign ring_wr_idx = {slot, dword_sel};

endmodule

// File: rtl/mdr_checker.sv
module mdr_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ring_full,
    input logic             ring_wr_en,
    input logic [IDX_W-1:0] ring_wr_idx,
    input logic [31:0]      ring_wr_data,
    input logic             desc_busy,
    input logic             desc_done
);

    AST_BEAT_01: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_wr_en && ring_wr_idx[1:0] == 2'd0) |=> (ring_wr_en && ring_wr_idx[1:0] == 2'd1)); // R1
    AST_BEAT_12: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_wr_en && ring_wr_idx[1:0] == 2'd1) |=> (ring_wr_en && ring_wr_idx[1:0] == 2'd2)); // R1
    AST_BEAT_23: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_wr_en && ring_wr_idx[1:0] == 2'd2) |=> (ring_wr_en && ring_wr_idx[1:0] == 2'd3)); // R1
    AST_SAME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_wr_en && ring_wr_idx[1:0] != 2'd3) |=> $stable(ring_wr_idx[IDX_W-1:2])); // R1
    AST_CTRL_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_wr_en && ring_wr_idx[1:0] == 2'd3) |-> (ring_wr_data[15:12] == 4'd0 && !ring_wr_data[19])); // R2
    AST_NO_START_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_wr_en) |-> !$past(ring_full)); // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_wr_en && ring_wr_idx[1:0] == 2'd3) |=> desc_done); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |=> !desc_done); // R8
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ring_wr_en |-> desc_busy); // R9

endmodule

bind mon_desc_ring_producer mdr_checker #(.IDX_W(IDX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ring_full    (ring_full),
    .ring_wr_en   (ring_wr_en),
    .ring_wr_idx  (ring_wr_idx),
    .ring_wr_data (ring_wr_data),
    .desc_busy    (desc_busy),
    .desc_done    (desc_done)
);

// File: tb/mon_desc_ring_producer_tb_top.sv
module mon_desc_ring_producer_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam int         DEPTH      = 4;
    localparam logic [7:0] RID        = 8'hA7;
    localparam int         IDX_W      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seg_start = 0, tlv_valid = 0;
    logic [11:0] tlv_offset = 0, tlv_size = 0;
    logic ev_trunc = 0, ev_flush = 0, ev_ppdu_end = 0, ev_buf_full = 0;
    logic initiator = 0;
    logic [31:0] sched_id = 32'h5C4E_D001, phy_ppdu_id = 32'h0000_BEEF;
    logic [63:0] buf_addr = 64'h1234_5678_9ABC_DEF0;
    logic ring_full = 0;
    logic ring_wr_en, desc_busy, desc_done;
    logic [IDX_W-1:0] ring_wr_idx;
    logic [31:0] ring_wr_data;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_desc_ring_producer #(.DEPTH(DEPTH), .RING_ID(RID)) dut_i (
        .clk(clk), .rst_n(rst_n), .seg_start(seg_start), .tlv_valid(tlv_valid),
        .tlv_offset(tlv_offset), .tlv_size(tlv_size), .ev_trunc(ev_trunc),
        .ev_flush(ev_flush), .ev_ppdu_end(ev_ppdu_end), .ev_buf_full(ev_buf_full),
        .initiator(initiator), .sched_id(sched_id), .phy_ppdu_id(phy_ppdu_id),
        .buf_addr(buf_addr), .ring_full(ring_full), .ring_wr_en(ring_wr_en),
        .ring_wr_idx(ring_wr_idx), .ring_wr_data(ring_wr_data),
        .desc_busy(desc_busy), .desc_done(desc_done)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_phase = 0;   // 0 idle, 1 held, 2..5 dword 0..3
    int          m_slot = 0, m_wrap = 0;
    logic [11:0] m_trk = 0;
    logic [31:0] m_beats [4];
    bit          m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_slot = 0; m_wrap = 0; m_trk = 0; m_done = 0;
        end else begin
            logic [11:0] tn;
            int rsn;
            bit done_n;
            done_n = (m_phase == 5);
            tn = seg_start ? 12'd0 : m_trk;
            if (tlv_valid && tlv_size != 0) tn = tlv_offset + tlv_size - 12'd1;
            if (m_phase == 0) begin
                if (ev_trunc || ev_flush || ev_ppdu_end || ev_buf_full) begin
                    rsn = ev_trunc ? 3 : ev_flush ? 1 : ev_ppdu_end ? 2 : 0;
                    m_beats[0] = buf_addr[31:0];
                    m_beats[1] = buf_addr[63:32];
                    m_beats[2] = initiator ? sched_id : phy_ppdu_id;
                    m_beats[3] = (32'(m_wrap) << 28) | (32'(RID) << 20) |
                                 (32'(initiator) << 18) | (32'(rsn) << 16) | 32'(tn);
                    m_phase = ring_full ? 1 : 2;
                end
            end else if (m_phase == 1) begin
                if (!ring_full) m_phase = 2;
            end else if (m_phase < 5) begin
                m_phase++;
            end else begin
                m_phase = 0;
                if (m_slot == DEPTH - 1) begin
                    m_slot = 0;
                    m_wrap = (m_wrap + 1) % 16;
                end else begin
                    m_slot++;
                end
            end
            m_trk  = tn;
            m_done = done_n;
        end
    end

    // ---------------- per-clock comparison and ring mirror ----------------
    logic [31:0] mirror [DEPTH*4];
    int          n_desc_seen = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R7 ring_wr_en", 32'(ring_wr_en), 32'(m_phase >= 2));
            check("R9 desc_busy", 32'(desc_busy), 32'(m_phase != 0));
            check("R8 desc_done", 32'(desc_done), 32'(m_done));
            if (m_phase >= 2 && ring_wr_en) begin
                check("R1 ring_wr_idx", 32'(ring_wr_idx), 32'(m_slot * 4 + m_phase - 2));
                check(m_phase == 4 ? "R5 dword2" : m_phase == 5 ? "R2 dword3" : "R1 address",
                      ring_wr_data, m_beats[m_phase - 2]);
            end
            if (ring_wr_en) begin
                mirror[ring_wr_idx] = ring_wr_data;
                if (ring_wr_idx[1:0] == 2'd3) n_desc_seen++;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(int n); repeat (n) @(negedge clk); endtask

    task automatic wait_idle();
        step(1);
        while (m_phase != 0) step(1);
        step(1);
    endtask

    task automatic fire(bit t, bit f, bit p, bit b);
        ev_trunc = t; ev_flush = f; ev_ppdu_end = p; ev_buf_full = b;
        step(1);
        ev_trunc = 0; ev_flush = 0; ev_ppdu_end = 0; ev_buf_full = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R10: reset state
        check("R10 wr_en after reset", 32'(ring_wr_en), 0);
        check("R10 busy after reset", 32'(desc_busy), 0);
        check("R10 done after reset", 32'(desc_done), 0);

        // S1: two TLVs, end of PPDU, initiator side
        seg_start = 1; tlv_valid = 1; tlv_offset = 0; tlv_size = 4;
        step(1);
        seg_start = 0; tlv_offset = 4; tlv_size = 10;
        step(1);
        tlv_valid = 0; initiator = 1;
        fire(0, 0, 1, 0);
        wait_idle();
        check("R10 first descriptor slot 0 dword0", mirror[0], 32'h9ABC_DEF0);
        check("R1 dword1 high address", mirror[1], 32'h1234_5678);
        check("R5 initiator selects schedule id", mirror[2], 32'h5C4E_D001);
        check("R2 control word layout", mirror[3], 32'h0A76_000D);
        check("R3 end offset last TLV", 32'(mirror[3][11:0]), 13);

        // S2: flush with TLV in the same cycle, responder side
        initiator = 0; tlv_valid = 1; tlv_offset = 20; tlv_size = 3;
        fire(0, 1, 0, 0);
        tlv_valid = 0;
        wait_idle();
        check("R5 responder selects PHY id", mirror[6], 32'h0000_BEEF);
        check("R3 same-cycle TLV counted on flush", mirror[7], 32'h0A71_0016);

        // S3: zero-size TLV ignored, buffer full
        tlv_valid = 1; tlv_offset = 100; tlv_size = 0;
        step(1);
        tlv_valid = 0;
        fire(0, 0, 0, 1);
        wait_idle();
        check("R3 zero-size TLV ignored", 32'(mirror[11][11:0]), 22);
        check("R4 buffer full code 0", 32'(mirror[11][17:16]), 0);

        // S4: all causes together -> truncation
        fire(1, 1, 1, 1);
        wait_idle();
        check("R4 truncation wins", mirror[15], 32'h0A73_0016);

        // S5: flush and end of PPDU together, after ring roll
        fire(0, 1, 1, 0);
        wait_idle();
        check("R6 wrap count 1 after roll", mirror[3], 32'h1A71_0016);

        // S6: ring full stall
        ring_full = 1;
        fire(0, 0, 1, 0);
        for (int i = 0; i < 6; i++) begin
            check("R7 no write while full", 32'(ring_wr_en), 0);
            step(1);
        end
        ring_full = 0;
        wait_idle();
        check("R7 held descriptor written", mirror[7], 32'h1A72_0016);

        // S7: cause while busy is ignored
        fire(0, 0, 1, 0);
        fire(0, 1, 0, 0);
        wait_idle();
        check("R9 busy cause dropped, one descriptor", 32'(n_desc_seen), 7);
        check("R9 reason from first cause", 32'(mirror[11][17:16]), 2);

        // S8: run the wrap count through 15 and back to 0
        for (int k = 7; k < 64; k++) begin
            fire(0, 0, 0, 1);
            wait_idle();
        end
        check("R6 wrap count 15", 32'(mirror[15][31:28]), 15);
        for (int k = 64; k < 68; k++) begin
            fire(0, 0, 0, 1);
            wait_idle();
        end
        check("R6 wrap count rolls to 0", 32'(mirror[15][31:28]), 0);
        check("R6 descriptor total", 32'(n_desc_seen), 68);

        finish_run();
    end

endmodule